// File: doc/BRIEF.md
# DMA Chain Tag Walker

This block holds the pointer-update rules of a DMA channel that runs in source-chain mode. The channel fetches a 128-bit tag from memory. It presents the tag's kind, its quadword count and its address field on one strobe. Before that strobe, the address field is the value already sitting in the data pointer. In the same cycle the block works out the next data pointer, the next tag pointer and whether the chain stops there. The new pointers are registered on the clock edge that closes the strobe cycle.

A chain start input loads the first tag address and clears everything else. A build parameter adds a two-slot return-address stack with a depth counter. With the stack built in, subroutine-style call and return tags can nest two levels deep. A call at full depth and a return at zero depth both stop the chain. Fetching the tags, moving the data and stall handling belong to the surrounding channel.

Top module: `dma_tag_walker`

## Requirements
- R1: After reset, and in the cycle after `chain_start`, the data pointer, the stack depth and both stack slots read zero. The tag pointer reads zero after reset and `start_tadr` after a start.
- R2: Kind code 0 (reference-and-stop) stops the chain. The tag pointer keeps its value and the data pointer takes the address field.
- R3: Kind code 1 (count) sets the data pointer to tag pointer + 16 and the tag pointer to tag pointer + 16 + qwc×16. The chain continues.
- R4: Kind code 2 (jump) sets the data pointer to tag pointer + 16 and the tag pointer to the address field. The chain continues.
- R5: Kind codes 3 and 4 (reference, and reference with stall) leave the data pointer at the address field and advance the tag pointer by 16. The chain continues.
- R6: Kind code 7 (stop) sets the data pointer to tag pointer + 16 and stops the chain. The tag pointer is unchanged.
- R7: With the stack built in, kind code 5 (call) with a non-zero field sets the data pointer to tag pointer + 16. It writes tag pointer + 16 + qwc×16 into slot 0 at depth 0 or into slot 1 at depth 1, adds one to the depth and loads the tag pointer from the field. The depth never exceeds 2.
- R8: A call at depth 2 with a non-zero field stops the chain. The data pointer becomes tag pointer + 16, and the tag pointer, the depth and both slots stay as they were.
- R9: A call whose field is zero writes no slot. It acts like a count tag and continues.
- R10: With the stack built in, kind code 6 (return) sets the data pointer to tag pointer + 16. At depth 2 it moves slot 1 into the tag pointer and clears slot 1. At depth 1 it does the same with slot 0. The depth drops by one and the chain continues.
- R11: A return at depth 0 stops the chain. The data pointer becomes tag pointer + 16 and the tag pointer is unchanged.
- R12: With the stack left out, calls and returns continue the chain. The data pointer takes the field, the tag pointer is kept, and the depth and slots stay zero.
- R13: `chain_end` is valid combinationally in the strobe cycle and is low without a strobe. All pointer updates land together on that cycle's edge. Without a strobe or start, every register holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| chain_start | input | 1 | Begin a new chain: load start_tadr, clear the rest |
| start_tadr | input | ADDR_W | Address of the first tag |
| tag_stb | input | 1 | A fetched tag is presented this cycle |
| tag_kind | input | 3 | Tag kind code |
| tag_qwc | input | QWC_W | Quadword count carried by the tag |
| tag_field | input | ADDR_W | Address field of the tag (current data pointer contents) |
| madr | output | ADDR_W | Data pointer |
| tadr | output | ADDR_W | Tag pointer |
| stack_ptr | output | 2 | Return stack depth |
| ret_slot0 | output | ADDR_W | Return stack slot 0 |
| ret_slot1 | output | ADDR_W | Return stack slot 1 |
| chain_end | output | 1 | The presented tag ends the chain |

## Verification
The bench builds two copies side by side. Both use 32-bit addresses and 16-bit counts. One has the return stack built in, which lets a sequence fill both slots, overflow, unwind and then underflow. The other has the stack left out, so calls and returns can be checked as ignored at the ports. The widest count, 0xFFFF, drives the tag pointer arithmetic well beyond the count's own width.

// File: rtl/dma_tag_pkg.sv
package dma_tag_pkg;

  // Tag kind codes; the channel's fetch stage decodes these bit values.
  typedef enum logic [2:0] {
    K_REF_STOP  = 3'd0,
    K_COUNT     = 3'd1,
    K_JUMP      = 3'd2,
    K_REF       = 3'd3,
    K_REF_STALL = 3'd4,
    K_CALL      = 3'd5,
    K_RETURN    = 3'd6,
    K_STOP      = 3'd7
  } tag_kind_e;

  // Source of the next tag pointer.
  typedef enum logic [2:0] {
    TSEL_HOLD  = 3'd0,
    TSEL_STEP  = 3'd1,
    TSEL_FIELD = 3'd2,
    TSEL_DATA  = 3'd3,
    TSEL_STACK = 3'd4
  } tadr_sel_e;

  localparam int unsigned RET_SLOTS  = 2;
  localparam int unsigned TAG_BYTES  = 16;

endpackage

// File: rtl/dma_tag_decode.sv
module dma_tag_decode
  import dma_tag_pkg::*;
#(
  parameter bit STACK_EN = 1'b1
) (
  input  tag_kind_e  kind,
  input  logic [1:0] depth,
  input  logic       field_zero,
  output logic       madr_after_tag,
  output tadr_sel_e  tadr_sel,
  output logic       want_push,
  output logic       want_pop,
  output logic       stop,
  output logic       overflow,
  output logic       underflow
);

  localparam logic [1:0] FULL_DEPTH = 2'(RET_SLOTS);

  always_comb begin
    madr_after_tag = 1'b0;
    tadr_sel       = TSEL_HOLD;
    want_push      = 1'b0;
    want_pop       = 1'b0;
    stop           = 1'b0;
    overflow       = 1'b0;
    underflow      = 1'b0;
    unique case (kind)
      K_REF_STOP: stop = 1'b1;
      K_COUNT: begin
        madr_after_tag = 1'b1;
        tadr_sel       = TSEL_DATA;
      end
      K_JUMP: begin
        madr_after_tag = 1'b1;
        tadr_sel       = TSEL_FIELD;
      end
      K_REF, K_REF_STALL: tadr_sel = TSEL_STEP;
      K_CALL: begin
        if (STACK_EN) begin
          madr_after_tag = 1'b1;
          if (field_zero) begin
            tadr_sel = TSEL_DATA;
          end else if (depth >= FULL_DEPTH) begin
            overflow = 1'b1;
            stop     = 1'b1;
          end else begin
            want_push = 1'b1;
            tadr_sel  = TSEL_FIELD;
          end
        end
      end
      K_RETURN: begin
        if (STACK_EN) begin
          madr_after_tag = 1'b1;
          if (depth == 2'd0 || depth > FULL_DEPTH) begin
            underflow = 1'b1;
            stop      = 1'b1;
          end else begin
            want_pop = 1'b1;
            tadr_sel = TSEL_STACK;
          end
        end
      end
      K_STOP: begin
        madr_after_tag = 1'b1;
        stop           = 1'b1;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/dma_ret_stack.sv
module dma_ret_stack
  import dma_tag_pkg::*;
#(
  parameter int unsigned ADDR_W   = 32,
  parameter bit          STACK_EN = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              push,
  input  logic              pop,
  input  logic [ADDR_W-1:0] push_val,
  output logic [1:0]        depth,
  output logic [ADDR_W-1:0] slot0,
  output logic [ADDR_W-1:0] slot1,
  output logic [ADDR_W-1:0] top
);

  if (STACK_EN) begin : g_stack
    logic [ADDR_W-1:0] slot_q [RET_SLOTS];
    logic [1:0]        depth_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        for (int i = 0; i < RET_SLOTS; i++) slot_q[i] <= '0;
        depth_q <= '0;
      end else if (clear) begin
        for (int i = 0; i < RET_SLOTS; i++) slot_q[i] <= '0;
        depth_q <= '0;
      end else if (push) begin
        slot_q[depth_q[0]] <= push_val;
        depth_q            <= depth_q + 2'd1;
      end else if (pop) begin
        slot_q[depth_q[1]] <= '0;
        depth_q            <= depth_q - 2'd1;
      end
    end

    assign depth = depth_q;
    assign slot0 = slot_q[0];
    assign slot1 = slot_q[1];
    assign top   = slot_q[depth_q[1]];
  end else begin : g_nostack
    logic unused_stack_in;
    assign unused_stack_in = ^{clk, rst_n, clear, push, pop, push_val};
    assign depth = '0;
    assign slot0 = '0;
    assign slot1 = '0;
    assign top   = '0;
  end

endmodule

// File: rtl/dma_tag_walker.sv
module dma_tag_walker
  import dma_tag_pkg::*;
#(
  parameter int unsigned ADDR_W   = 32,
  parameter int unsigned QWC_W    = 16,
  parameter bit          STACK_EN = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              chain_start,
  input  logic [ADDR_W-1:0] start_tadr,
  input  logic              tag_stb,
  input  logic [2:0]        tag_kind,
  input  logic [QWC_W-1:0]  tag_qwc,
  input  logic [ADDR_W-1:0] tag_field,
  output logic [ADDR_W-1:0] madr,
  output logic [ADDR_W-1:0] tadr,
  output logic [1:0]        stack_ptr,
  output logic [ADDR_W-1:0] ret_slot0,
  output logic [ADDR_W-1:0] ret_slot1,
  output logic              chain_end
);

  localparam int unsigned WIDE_W = ADDR_W + QWC_W + 4;

  function automatic logic [ADDR_W-1:0] qw_bytes(input logic [QWC_W-1:0] q);
    logic [WIDE_W-1:0] wide;
    wide = {{ADDR_W{1'b0}}, q, 4'b0000};
    return wide[ADDR_W-1:0];
  endfunction

  function automatic logic [ADDR_W-1:0] past_tag(input logic [ADDR_W-1:0] a);
    return a + ADDR_W'(TAG_BYTES);
  endfunction

  logic [ADDR_W-1:0] madr_q, tadr_q;
  logic [ADDR_W-1:0] after_tag, after_data, stack_top;
  logic [ADDR_W-1:0] madr_nxt, tadr_nxt;
  logic              tag_take;
  logic              dec_madr_after, dec_push, dec_pop, dec_stop;
  logic              dec_overflow, dec_underflow;
  tadr_sel_e         dec_tsel;

  // Named events for the checker.
  logic push_fire, pop_fire, stack_overflow, stack_underflow;

  assign tag_take   = tag_stb && !chain_start;
  assign after_tag  = past_tag(tadr_q);
  assign after_data = after_tag + qw_bytes(tag_qwc);

  dma_tag_decode #(.STACK_EN(STACK_EN)) u_dec (
    .kind           (tag_kind_e'(tag_kind)),
    .depth          (stack_ptr),
    .field_zero     (tag_field == '0),
    .madr_after_tag (dec_madr_after),
    .tadr_sel       (dec_tsel),
    .want_push      (dec_push),
    .want_pop       (dec_pop),
    .stop           (dec_stop),
    .overflow       (dec_overflow),
    .underflow      (dec_underflow)
  );

  assign push_fire       = tag_take && dec_push;
  assign pop_fire        = tag_take && dec_pop;
  assign stack_overflow  = tag_take && dec_overflow;
  assign stack_underflow = tag_take && dec_underflow;

  dma_ret_stack #(.ADDR_W(ADDR_W), .STACK_EN(STACK_EN)) u_stack (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (chain_start),
    .push     (push_fire),
    .pop      (pop_fire),
    .push_val (after_data),
    .depth    (stack_ptr),
    .slot0    (ret_slot0),
    .slot1    (ret_slot1),
    .top      (stack_top)
  );

  assign madr_nxt = dec_madr_after ? after_tag : tag_field;

  always_comb begin
    unique case (dec_tsel)
      TSEL_STEP:  tadr_nxt = after_tag;
      TSEL_FIELD: tadr_nxt = tag_field;
      TSEL_DATA:  tadr_nxt = after_data;
      TSEL_STACK: tadr_nxt = stack_top;
      default:    tadr_nxt = tadr_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      madr_q <= '0;
      tadr_q <= '0;
    end else if (chain_start) begin
      madr_q <= '0;
      tadr_q <= start_tadr;
    end else if (tag_stb) begin
      madr_q <= madr_nxt;
      tadr_q <= tadr_nxt;
    end
  end

  assign madr      = madr_q;
  assign tadr      = tadr_q;
  assign chain_end = tag_take && dec_stop;

endmodule

// File: rtl/dma_tag_walker_chk.sv
module dma_tag_walker_chk #(
  parameter int unsigned ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              chain_start,
  input logic [ADDR_W-1:0] start_tadr,
  input logic              tag_stb,
  input logic [ADDR_W-1:0] madr,
  input logic [ADDR_W-1:0] tadr,
  input logic [1:0]        stack_ptr,
  input logic [ADDR_W-1:0] ret_slot1,
  input logic              chain_end,
  input logic              push_fire,
  input logic              pop_fire,
  input logic              stack_overflow,
  input logic              stack_underflow
);

  assert_start_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
    chain_start |=> (stack_ptr == 2'd0 && madr == '0 && tadr == $past(start_tadr)));

  assert_depth_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    stack_ptr <= 2'd2);

  assert_push_depth_R7: assert property (@(posedge clk) disable iff (!rst_n)
    push_fire |=> stack_ptr == 2'($past(stack_ptr) + 2'd1));

  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    stack_overflow |-> (chain_end && !push_fire));

  assert_overflow_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    stack_overflow |=> ($stable(tadr) && $stable(stack_ptr) && $stable(ret_slot1)));

  assert_pop_top_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_fire && stack_ptr == 2'd2) |=> (tadr == $past(ret_slot1) && ret_slot1 == '0 && stack_ptr == 2'd1));

  assert_underflow_end_R11: assert property (@(posedge clk) disable iff (!rst_n)
    stack_underflow |-> (chain_end && !pop_fire));

  assert_end_needs_strobe_R13: assert property (@(posedge clk) disable iff (!rst_n)
    chain_end |-> tag_stb);

  assert_idle_hold_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (!tag_stb && !chain_start) |=> ($stable(tadr) && $stable(madr) && $stable(stack_ptr)));

endmodule

bind dma_tag_walker dma_tag_walker_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .chain_start     (chain_start),
  .start_tadr      (start_tadr),
  .tag_stb         (tag_stb),
  .madr            (madr),
  .tadr            (tadr),
  .stack_ptr       (stack_ptr),
  .ret_slot1       (ret_slot1),
  .chain_end       (chain_end),
  .push_fire       (push_fire),
  .pop_fire        (pop_fire),
  .stack_overflow  (stack_overflow),
  .stack_underflow (stack_underflow)
);

// File: tb/sim_dma_tag_walker.sv
module sim_dma_tag_walker;

  localparam int unsigned AW = 32;
  localparam int unsigned QW = 16;

  typedef struct packed {
    logic [2:0]    k;
    logic [QW-1:0] q;
    logic [AW-1:0] f;
    logic [AW-1:0] m;
    logic [AW-1:0] t;
    logic          e;
    logic [1:0]    sp;
  } vec_t;

  // Each row: fresh chain at tag address 0x1000, one tag, expected result.
  localparam int NV = 11;
  localparam vec_t VT [NV] = '{
    '{3'd0, 16'd3,    32'h2000, 32'h2000, 32'h1000,   1'b1, 2'd0}, // R2
    '{3'd1, 16'd3,    32'h2000, 32'h1010, 32'h1040,   1'b0, 2'd0}, // R3
    '{3'd2, 16'd2,    32'h3000, 32'h1010, 32'h3000,   1'b0, 2'd0}, // R4
    '{3'd3, 16'd5,    32'h4000, 32'h4000, 32'h1010,   1'b0, 2'd0}, // R5
    '{3'd4, 16'd1,    32'h4400, 32'h4400, 32'h1010,   1'b0, 2'd0}, // R5
    '{3'd7, 16'd2,    32'h5000, 32'h1010, 32'h1000,   1'b1, 2'd0}, // R6
    '{3'd5, 16'd2,    32'h6000, 32'h1010, 32'h6000,   1'b0, 2'd1}, // R7
    '{3'd5, 16'd4,    32'h0,    32'h1010, 32'h1050,   1'b0, 2'd0}, // R9
    '{3'd6, 16'd1,    32'h7000, 32'h1010, 32'h1000,   1'b1, 2'd0}, // R11
    '{3'd1, 16'd0,    32'h0,    32'h1010, 32'h1010,   1'b0, 2'd0}, // R3
    '{3'd1, 16'hFFFF, 32'h0,    32'h1010, 32'h101000, 1'b0, 2'd0}  // R3
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          chain_start = 1'b0;
  logic [AW-1:0] start_tadr = '0;
  logic          tag_stb = 1'b0;
  logic [2:0]    tag_kind = '0;
  logic [QW-1:0] tag_qwc = '0;
  logic [AW-1:0] tag_field = '0;

  logic [AW-1:0] madr0, tadr0, s00, s10, madr1, tadr1, s01, s11;
  logic [1:0]    sp0, sp1;
  logic          end0, end1;

  int total = 0;
  int bad = 0;
  logic e0, e1;

  always #5 clk = ~clk;

  dma_tag_walker #(.ADDR_W(AW), .QWC_W(QW), .STACK_EN(1'b1)) u0 (
    .clk(clk), .rst_n(rst_n), .chain_start(chain_start), .start_tadr(start_tadr),
    .tag_stb(tag_stb), .tag_kind(tag_kind), .tag_qwc(tag_qwc), .tag_field(tag_field),
    .madr(madr0), .tadr(tadr0), .stack_ptr(sp0), .ret_slot0(s00), .ret_slot1(s10),
    .chain_end(end0));

  dma_tag_walker #(.ADDR_W(AW), .QWC_W(QW), .STACK_EN(1'b0)) u1 (
    .clk(clk), .rst_n(rst_n), .chain_start(chain_start), .start_tadr(start_tadr),
    .tag_stb(tag_stb), .tag_kind(tag_kind), .tag_qwc(tag_qwc), .tag_field(tag_field),
    .madr(madr1), .tadr(tadr1), .stack_ptr(sp1), .ret_slot0(s01), .ret_slot1(s11),
    .chain_end(end1));

  task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, got, exp);
    end
  endtask

  task automatic seed(input logic [AW-1:0] t);
    @(negedge clk);
    chain_start = 1'b1;
    start_tadr  = t;
    @(negedge clk);
    chain_start = 1'b0;
  endtask

  task automatic present(input logic [2:0] k, input logic [QW-1:0] q, input logic [AW-1:0] f);
    @(negedge clk);
    tag_stb = 1'b1; tag_kind = k; tag_qwc = q; tag_field = f;
    #1;
    e0 = end0;
    e1 = end1;
    @(negedge clk);
    tag_stb = 1'b0;
  endtask

  initial begin
    #(200000 * 10);
    total++;
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 madr", madr0, 0);
    chk("R1 tadr", tadr0, 0);
    chk("R1 depth", sp0, 0);
    chk("R1 slots", {s00, s10}, 0);
    chk("R13 end idle", end0, 0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      seed(32'h1000);
      present(VT[i].k, VT[i].q, VT[i].f);
      chk($sformatf("R%0d vec%0d end", 13, i), e0, VT[i].e);
      chk($sformatf("vec%0d madr", i), madr0, VT[i].m);
      chk($sformatf("vec%0d tadr", i), tadr0, VT[i].t);
      chk($sformatf("vec%0d depth", i), sp0, VT[i].sp);
    end

    // R7 push twice, then R8 overflow
    seed(32'h1000);
    present(3'd5, 16'd1, 32'h2000);
    chk("R7 slot0", s00, 32'h1020);
    chk("R7 tadr", tadr0, 32'h2000);
    present(3'd5, 16'd2, 32'h3000);
    chk("R7 madr", madr0, 32'h2010);
    chk("R7 slot1", s10, 32'h2030);
    chk("R7 depth2", sp0, 2);
    present(3'd5, 16'd1, 32'h4000);
    chk("R8 end", e0, 1);
    chk("R8 madr", madr0, 32'h3010);
    chk("R8 tadr", tadr0, 32'h3000);
    chk("R8 depth", sp0, 2);
    chk("R8 slots", {s00, s10}, {32'h1020, 32'h2030});

    // R10 unwind, R11 underflow
    present(3'd6, 16'd0, 32'h9000);
    chk("R10 end", e0, 0);
    chk("R10 madr", madr0, 32'h3010);
    chk("R10 tadr", tadr0, 32'h2030);
    chk("R10 slot1 cleared", s10, 0);
    chk("R10 depth1", sp0, 1);
    present(3'd6, 16'd0, 32'h9000);
    chk("R10 tadr2", tadr0, 32'h1020);
    chk("R10 slot0 cleared", s00, 0);
    chk("R10 depth0", sp0, 0);
    chk("R10 madr2", madr0, 32'h2040);
    present(3'd6, 16'd0, 32'h9000);
    chk("R11 end", e0, 1);
    chk("R11 madr", madr0, 32'h1030);
    chk("R11 tadr", tadr0, 32'h1020);

    // R13 idle cycles hold state and keep end low
    repeat (3) @(negedge clk);
    chk("R13 hold tadr", tadr0, 32'h1020);
    chk("R13 hold madr", madr0, 32'h1030);
    chk("R13 no end", end0, 0);

    // R1 start clears a non-empty stack
    present(3'd5, 16'd1, 32'h5000);
    chk("R7 depth1", sp0, 1);
    seed(32'h8000);
    chk("R1 start depth", sp0, 0);
    chk("R1 start slot0", s00, 0);
    chk("R1 start tadr", tadr0, 32'h8000);
    chk("R1 start madr", madr0, 0);

    // R12 stack left out: call and return ignored
    seed(32'h1000);
    present(3'd5, 16'd2, 32'h6000);
    chk("R12 call end", e1, 0);
    chk("R12 call madr", madr1, 32'h6000);
    chk("R12 call tadr", tadr1, 32'h1000);
    chk("R12 call depth", sp1, 0);
    chk("R12 call slots", {s01, s11}, 0);
    present(3'd6, 16'd2, 32'h6100);
    chk("R12 ret end", e1, 0);
    chk("R12 ret madr", madr1, 32'h6100);
    chk("R12 ret tadr", tadr1, 32'h1000);
    present(3'd1, 16'd1, 32'h0);
    chk("R12 count still works", tadr1, 32'h1020);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule